// File: doc/BRIEF.md
# NAND Prefetch and Write-Post Engine

This block moves a programmed number of bytes between an 8-bit NAND data port and a 64-byte local FIFO without the CPU touching each byte. In read mode it strobes bytes in from the device whenever the device is ready and the FIFO has room, and the host drains them as 32-bit words. In write mode the host fills the FIFO with 16-bit halfwords, and the engine strobes those bytes out to the device.

Software programs two configuration words and then starts the engine through a control register. The first word holds an owner chip-select tag, a FIFO threshold, an enable, a request-mode select and the direction. The second holds the byte count. The engine refuses a restart while it is running and locks its configuration until it is stopped. A single status word shows both the FIFO occupancy and the bytes still to move. A threshold request goes out either as a DMA request or as an interrupt flag, and a sticky completion flag marks the end of the transfer.

Top module: `nand_pf_engine`

## Requirements
- R1: After reset, every register reads zero, the FIFO is empty, and the two strobes and both request outputs are low.
- R2: Register addresses are: 0 config word 1, 1 config word 2 (byte count in bits 13:0), 2 control (run in bit 0), 3 status, 4 done flag (bit 0). Config word 1 keeps the chip-select tag in bits 26:24, the threshold in bits 14:8, enable in bit 7, request mode in bit 2 (1 = DMA, 0 = interrupt) and direction in bit 0 (0 = read prefetch, 1 = write post). It reads back as written.
- R3: A write to config word 1 whose threshold exceeds 64 is ignored in full.
- R4: Writing 1 to control bit 0 starts the engine only when control reads 0 and enable is set. A start loads the remaining count from config word 2 and empties the FIFO. A start write while running changes nothing.
- R5: Writes to either config word while control is nonzero are ignored.
- R6: In read mode, in every cycle where the engine is running, the device is ready, the remaining count is nonzero and the FIFO is not full, the engine raises the read strobe. It pushes the input byte into the FIFO at that clock edge and lowers the remaining count by one.
- R7: A host pop takes 4 bytes when the FIFO holds at least 4. The oldest byte appears in bits 7:0 of the pop word. With fewer than 4 bytes held, a pop is ignored.
- R8: In write mode, a host push adds a halfword (low byte first) only while running with at least 2 bytes free; otherwise it is ignored. In each cycle where the device is ready, the FIFO is not empty and the remaining count is nonzero, the write strobe goes out with the oldest byte, and the remaining count drops by one.
- R9: Status holds the FIFO byte count in bits 30:24 and the remaining count in bits 13:0, with all other bits zero.
- R10: While running, the request is high when occupancy is at least the threshold (read mode) or free space is at least the threshold (write mode). The request drives the DMA request output in DMA mode and the interrupt output otherwise. The other output stays low.
- R11: The done flag sets one cycle after the running engine has a zero remaining count and, in write mode, an empty FIFO. Writing 1 to flag bit 0 clears it, unless the set condition holds in that same cycle.
- R12: Writing 0 to control stops the engine. No strobe follows, the remaining count freezes, and the config words become writable again.
- R13: The read and write strobes are never high together, and neither is high while the device is not ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| fifo_rd | input | 1 | Host pop of one 32-bit word (read mode) |
| fifo_rdata | output | 32 | Oldest four FIFO bytes, oldest in bits 7:0 |
| fifo_wr | input | 1 | Host push of one halfword (write mode) |
| fifo_wdata | input | 16 | Halfword to push, low byte first |
| nand_rdy | input | 1 | Device ready |
| nand_din | input | 8 | Byte from the device, sampled on a read strobe |
| nand_re | output | 1 | Read strobe |
| nand_we | output | 1 | Write strobe |
| nand_dout | output | 8 | Byte to the device, valid with the write strobe |
| dma_req | output | 1 | Threshold request in DMA mode |
| irq_req | output | 1 | Threshold request in interrupt mode |

## Verification
Strobes, the pop word, the outgoing byte and both requests are combinational from registered state and the ready input. The bench therefore changes inputs at the falling edge and samples these outputs a nanosecond later in the same half cycle. A register write or strobe shows up in status and readback after exactly one rising edge, and the done flag after one more edge than the zero count it depends on. Every readback check comes at the falling edge that follows those edges. Write-post bytes are compared by a monitor that samples two nanoseconds after each falling edge, once the ready input has settled.

// File: rtl/nand_pf_pkg.sv
package nand_pf_pkg;

    parameter int unsigned PF_DEPTH   = 64;
    parameter int unsigned PF_CNT_W   = 14;
    parameter int unsigned PF_THR_MAX = 64;

    typedef enum logic [2:0] {
        RA_CFG1 = 3'd0,
        RA_CFG2 = 3'd1,
        RA_CTRL = 3'd2,
        RA_STAT = 3'd3,
        RA_FLAG = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic [2:0] cs;
        logic [6:0] thr;
        logic       en;
        logic       dma;
        logic       dir;
    } cfg_t;

    function automatic cfg_t unpack_cfg(input logic [31:0] w);
        cfg_t c;
        c.cs  = w[26:24];
        c.thr = w[14:8];
        c.en  = w[7];
        c.dma = w[2];
        c.dir = w[0];
        return c;
    endfunction

    function automatic logic [31:0] pack_cfg(input cfg_t c);
        logic [31:0] w;
        w        = '0;
        w[26:24] = c.cs;
        w[14:8]  = c.thr;
        w[7]     = c.en;
        w[2]     = c.dma;
        w[0]     = c.dir;
        return w;
    endfunction

endpackage

// File: rtl/nand_pf_regs.sv
module nand_pf_regs
    import nand_pf_pkg::*;
#(
    parameter int unsigned CNT_W   = PF_CNT_W,
    parameter int unsigned THR_MAX = PF_THR_MAX
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [31:0]      wdata,
    input  logic             busy,
    output cfg_t             cfg,
    output logic [CNT_W-1:0] xfer_len,
    output logic             start,
    output logic             stop,
    output logic             flag_clr
);
    cfg_t new_cfg;
    logic unused_wdata;

    assign new_cfg      = unpack_cfg(wdata);
    assign unused_wdata = ^wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '0;
            xfer_len <= '0;
        end else if (wr_en && !busy) begin
            if (addr == RA_CFG1 && 32'(new_cfg.thr) <= THR_MAX)
                cfg <= new_cfg;
            if (addr == RA_CFG2)
                xfer_len <= wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        start    = wr_en && addr == RA_CTRL && wdata[0] && !busy && cfg.en;
        stop     = wr_en && addr == RA_CTRL && !wdata[0];
        flag_clr = wr_en && addr == RA_FLAG && wdata[0];
    end
endmodule

// File: rtl/nand_pf_fifo.sv
module nand_pf_fifo #(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned PW   = $clog2(DEPTH),
    localparam int unsigned CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push1,
    input  logic [7:0]    push1_data,
    input  logic          push2,
    input  logic [15:0]   push2_data,
    input  logic          pop1,
    input  logic          pop4,
    output logic [31:0]   head4,
    output logic [CW-1:0] count
);
    // DEPTH must be a power of two: pointers wrap by overflow.
    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [CW-1:0] n_in, n_out;

    always_comb begin
        n_in  = push2 ? CW'(2) : (push1 ? CW'(1) : CW'(0));
        n_out = pop4  ? CW'(4) : (pop1  ? CW'(1) : CW'(0));
    end

    for (genvar k = 0; k < 4; k++) begin : g_head
        assign head4[8*k +: 8] = mem[rptr + PW'(k)];
    end

    always_ff @(posedge clk) begin
        if (push1)
            mem[wptr] <= push1_data;
        else if (push2) begin
            mem[wptr]          <= push2_data[7:0];
            mem[wptr + PW'(1)] <= push2_data[15:8];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            wptr  <= wptr + n_in[PW-1:0];
            rptr  <= rptr + n_out[PW-1:0];
            count <= count + n_in - n_out;
        end
    end
endmodule

// File: rtl/nand_pf_xfer.sv
module nand_pf_xfer #(
    parameter int unsigned CNT_W = 14,
    parameter int unsigned DEPTH = 64,
    localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             stop,
    input  logic             flag_clr,
    input  logic [CNT_W-1:0] xfer_len,
    input  logic             dir,
    input  logic             dma,
    input  logic [6:0]       thr,
    input  logic             nand_rdy,
    input  logic [CW-1:0]    fifo_cnt,
    output logic             run,
    output logic [CNT_W-1:0] remain,
    output logic             nand_re,
    output logic             nand_we,
    output logic             done,
    output logic             dma_req,
    output logic             irq_req
);
    logic          can_move, done_set, req;
    logic [CW-1:0] fifo_free;

    always_comb begin
        fifo_free = CW'(DEPTH) - fifo_cnt;
        can_move  = run && remain != '0 && nand_rdy;
        nand_re   = can_move && !dir && 32'(fifo_cnt) < 32'(DEPTH);
        nand_we   = can_move && dir && fifo_cnt != '0;
        done_set  = run && remain == '0 && (!dir || fifo_cnt == '0);
        req       = run && (dir ? 32'(fifo_free) >= 32'(thr)
                                : 32'(fifo_cnt)  >= 32'(thr));
        dma_req   = req && dma;
        irq_req   = req && !dma;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run    <= 1'b0;
            remain <= '0;
        end else if (start) begin
            run    <= 1'b1;
            remain <= xfer_len;
        end else begin
            if (stop)
                run <= 1'b0;
            if (nand_re || nand_we)
                remain <= remain - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            done <= 1'b0;
        else if (done_set)
            done <= 1'b1;
        else if (flag_clr)
            done <= 1'b0;
    end
endmodule

// File: rtl/nand_pf_engine.sv
module nand_pf_engine
    import nand_pf_pkg::*;
#(
    parameter int unsigned DEPTH   = PF_DEPTH,
    parameter int unsigned CNT_W   = PF_CNT_W,
    parameter int unsigned THR_MAX = PF_THR_MAX,
    localparam int unsigned CW     = $clog2(DEPTH) + 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        fifo_rd,
    output logic [31:0] fifo_rdata,
    input  logic        fifo_wr,
    input  logic [15:0] fifo_wdata,
    input  logic        nand_rdy,
    input  logic [7:0]  nand_din,
    output logic        nand_re,
    output logic        nand_we,
    output logic [7:0]  nand_dout,
    output logic        dma_req,
    output logic        irq_req
);
    cfg_t             cfg;
    logic [31:0]      cfg_word;
    logic [CNT_W-1:0] xfer_len, remain;
    logic             start, stop, flag_clr, run, done;
    logic [CW-1:0]    fifo_cnt, fifo_free;
    logic             pop4, push2;
    logic [31:0]      head4;

    nand_pf_regs #(.CNT_W(CNT_W), .THR_MAX(THR_MAX)) u_regs (
        .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .busy(run), .cfg(cfg), .xfer_len(xfer_len),
        .start(start), .stop(stop), .flag_clr(flag_clr)
    );

    nand_pf_xfer #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u_xfer (
        .clk(clk), .rst(rst), .start(start), .stop(stop),
        .flag_clr(flag_clr), .xfer_len(xfer_len), .dir(cfg.dir),
        .dma(cfg.dma), .thr(cfg.thr), .nand_rdy(nand_rdy),
        .fifo_cnt(fifo_cnt), .run(run), .remain(remain),
        .nand_re(nand_re), .nand_we(nand_we), .done(done),
        .dma_req(dma_req), .irq_req(irq_req)
    );

    always_comb begin
        fifo_free = CW'(DEPTH) - fifo_cnt;
        pop4      = fifo_rd && !cfg.dir && 32'(fifo_cnt) >= 32'd4;
        push2     = fifo_wr && run && cfg.dir && 32'(fifo_free) >= 32'd2;
    end

    nand_pf_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .flush(start),
        .push1(nand_re), .push1_data(nand_din),
        .push2(push2), .push2_data(fifo_wdata),
        .pop1(nand_we), .pop4(pop4),
        .head4(head4), .count(fifo_cnt)
    );

    assign fifo_rdata = head4;
    assign nand_dout  = head4[7:0];
    assign cfg_word   = pack_cfg(cfg);

    always_comb begin
        case (reg_addr)
            RA_CFG1: reg_rdata = cfg_word;
            RA_CFG2: reg_rdata = 32'(xfer_len);
            RA_CTRL: reg_rdata = {31'b0, run};
            RA_STAT: reg_rdata = (32'(fifo_cnt) << 24) | 32'(remain);
            RA_FLAG: reg_rdata = {31'b0, done};
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/nand_pf_engine_chk.sv
module nand_pf_engine_chk #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned CNT_W = 14,
    parameter int unsigned CW    = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             nand_re,
    input logic             nand_we,
    input logic             nand_rdy,
    input logic             run,
    input logic [CNT_W-1:0] remain,
    input logic [CW-1:0]    fifo_cnt,
    input logic [31:0]      cfg_word
);
    p_strobe_excl_r13: assert property (@(posedge clk) disable iff (rst)
        !(nand_re && nand_we));

    p_strobe_rdy_r13: assert property (@(posedge clk) disable iff (rst)
        (nand_re || nand_we) |-> nand_rdy);

    p_fifo_bound_r9: assert property (@(posedge clk) disable iff (rst)
        32'(fifo_cnt) <= 32'(DEPTH));

    p_count_step_r6: assert property (@(posedge clk) disable iff (rst)
        (run && (nand_re || nand_we)) |=> remain == $past(remain) - CNT_W'(1));

    p_cfg_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run)) |-> $stable(cfg_word));
endmodule

bind nand_pf_engine nand_pf_engine_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .CW(CW)) u_chk (
    .clk(clk), .rst(rst), .nand_re(nand_re), .nand_we(nand_we),
    .nand_rdy(nand_rdy), .run(run), .remain(remain),
    .fifo_cnt(fifo_cnt), .cfg_word(cfg_word)
);

// File: tb/nand_pf_engine_bench.sv
module nand_pf_engine_bench;
    localparam logic [2:0] A_CFG1 = 3'd0, A_CFG2 = 3'd1, A_CTRL = 3'd2,
                           A_STAT = 3'd3, A_FLAG = 3'd4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = A_STAT;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fifo_rd = 1'b0;
    logic [31:0] fifo_rdata;
    logic        fifo_wr = 1'b0;
    logic [15:0] fifo_wdata = '0;
    logic        nand_rdy = 1'b0;
    logic [7:0]  nand_din;
    logic        nand_re, nand_we;
    logic [7:0]  nand_dout;
    logic        dma_req, irq_req;

    int vecs = 0;
    int fails = 0;
    int rd_idx = 0;   // bytes the device model has supplied
    int e_idx  = 0;   // next byte expected at the host pop side
    int wpush  = 0;   // bytes accepted by the host push side
    int widx   = 0;   // bytes observed leaving on the write strobe

    always #4 clk = ~clk;

    function automatic logic [7:0] rpat(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    function automatic logic [7:0] wpat(input int i);
        return 8'(((i * 53 + 5) & 255) ^ 8'h5A);
    endfunction

    function automatic logic [31:0] mkcfg(input int cs, input int thr,
                                          input bit en, input bit dma, input bit dir);
        return (32'(cs & 7) << 24) | (32'(thr & 127) << 8) |
               (32'(en) << 7) | (32'(dma) << 2) | 32'(dir);
    endfunction

    function automatic bit rdy_pat(input int mode, input int cyc);
        case (mode)
            0: return 1'b1;
            1: return (cyc % 3) != 2;
            2: return ((cyc / 5) % 2) == 0;
            default: return (cyc % 4) == 0;
        endcase
    endfunction

    assign nand_din = rpat(rd_idx);
    always @(posedge clk) if (nand_re) rd_idx <= rd_idx + 1;

    nand_pf_engine u_nand_pf_engine (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fifo_rd(fifo_rd),
        .fifo_rdata(fifo_rdata), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
        .nand_rdy(nand_rdy), .nand_din(nand_din), .nand_re(nand_re),
        .nand_we(nand_we), .nand_dout(nand_dout), .dma_req(dma_req),
        .irq_req(irq_req)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h @%0t", tag, act, exp, $time);
        end
    endtask

    // Write-post monitor: each outgoing byte must follow the pushed order (R8).
    always @(negedge clk) begin
        #2;
        if (nand_we) begin
            chk(nand_dout == wpat(widx), "R8 write strobe byte", 32'(nand_dout), 32'(wpat(widx)));
            widx++;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = A_STAT;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic shut_down();
        logic [31:0] v;
        wr(A_CTRL, 32'd0);
        rd(A_CTRL, v);
        chk(v == 32'd0, "R12 control after stop", v, 32'd0);
        wr(A_FLAG, 32'd1);
        rd(A_FLAG, v);
        chk(v == 32'd0, "R11 flag after clear", v, 32'd0);
        wr(A_CFG1, 32'd0);
    endtask

    task automatic run_read(input int len, input int mode, input int thr, input bit dma);
        logic [31:0] s, v, exp_w;
        int got = 0, cyc = 0, guard = 0, cnt;
        bit req;
        wr(A_CFG1, mkcfg(len, thr, 1'b1, dma, 1'b0));
        wr(A_CFG2, 32'(len));
        rd(A_CFG1, v);
        chk(v == mkcfg(len, thr, 1'b1, dma, 1'b0), "R2 config readback", v, mkcfg(len, thr, 1'b1, dma, 1'b0));
        e_idx = rd_idx;
        wr(A_CTRL, 32'd1);
        while (got < len && guard < 4000) begin
            @(negedge clk);
            fifo_rd = 1'b0;
            nand_rdy = rdy_pat(mode, cyc);
            cyc++; guard++;
            rd(A_STAT, s);
            cnt = int'(s[30:24]);
            req = cnt >= thr;
            chk(dma_req == (dma && req) && irq_req == (!dma && req), "R10 read request",
                {30'b0, dma_req, irq_req}, {30'b0, dma && req, !dma && req});
            if (cnt >= 4) begin
                exp_w = {rpat(e_idx + 3), rpat(e_idx + 2), rpat(e_idx + 1), rpat(e_idx)};
                chk(fifo_rdata == exp_w, "R6 R7 popped word", fifo_rdata, exp_w);
                fifo_rd = 1'b1;
                e_idx += 4; got += 4;
            end
        end
        @(negedge clk);
        fifo_rd = 1'b0;
        nand_rdy = 1'b0;
        rd(A_STAT, s);
        chk(s == 32'd0, "R9 status after read drain", s, 32'd0);
        rd(A_FLAG, v);
        chk(v == 32'd1, "R11 done after read", v, 32'd1);
        shut_down();
    endtask

    task automatic run_write(input int len, input int mode, input int thr, input bit dma);
        logic [31:0] s, v;
        int pushed = 0, cyc = 0, guard = 0, free;
        bit req;
        wr(A_CFG1, mkcfg(mode, thr, 1'b1, dma, 1'b1));
        wr(A_CFG2, 32'(len));
        wr(A_CTRL, 32'd1);
        while (!(pushed == len && widx == wpush) && guard < 4000) begin
            @(negedge clk);
            fifo_wr = 1'b0;
            nand_rdy = rdy_pat(mode, cyc);
            cyc++; guard++;
            rd(A_STAT, s);
            free = 64 - int'(s[30:24]);
            req = free >= thr;
            chk(dma_req == (dma && req) && irq_req == (!dma && req), "R10 write request",
                {30'b0, dma_req, irq_req}, {30'b0, dma && req, !dma && req});
            if (pushed < len && free >= 2) begin
                fifo_wr = 1'b1;
                fifo_wdata = {wpat(wpush + 1), wpat(wpush)};
                wpush += 2; pushed += 2;
            end
        end
        @(negedge clk);
        fifo_wr = 1'b0;
        nand_rdy = 1'b0;
        rd(A_STAT, s);
        chk(s == 32'd0, "R9 status after write drain", s, 32'd0);
        rd(A_FLAG, v);
        chk(v == 32'd1, "R11 done after write", v, 32'd1);
        shut_down();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        logic [31:0] v, s, r0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            chk(v == 32'd0, "R1 register after reset", v, 32'd0);
        end
        chk({nand_re, nand_we, dma_req, irq_req} == 4'b0, "R1 outputs after reset",
            {28'b0, nand_re, nand_we, dma_req, irq_req}, 32'd0);

        // R2 / R3: threshold limit
        wr(A_CFG1, mkcfg(5, 64, 1'b0, 1'b1, 1'b1));
        rd(A_CFG1, v);
        chk(v == mkcfg(5, 64, 1'b0, 1'b1, 1'b1), "R2 fields at maximum threshold", v, mkcfg(5, 64, 1'b0, 1'b1, 1'b1));
        wr(A_CFG1, mkcfg(2, 65, 1'b1, 1'b0, 1'b0));
        rd(A_CFG1, v);
        chk(v == mkcfg(5, 64, 1'b0, 1'b1, 1'b1), "R3 over-limit threshold ignored", v, mkcfg(5, 64, 1'b0, 1'b1, 1'b1));

        // R4: start refused while disabled
        wr(A_CFG2, 32'd9);
        wr(A_CTRL, 32'd1);
        rd(A_CTRL, v);
        chk(v == 32'd0, "R4 start with enable clear", v, 32'd0);

        // R4 / R5 / R12: locked configuration and restart refusal
        nand_rdy = 1'b0;
        wr(A_CFG1, mkcfg(1, 8, 1'b1, 1'b0, 1'b0));
        wr(A_CFG2, 32'd20);
        wr(A_CTRL, 32'd1);
        rd(A_STAT, s);
        chk(s == 32'd20, "R4 start loads remaining", s, 32'd20);
        wr(A_CFG2, 32'd5);
        rd(A_CFG2, v);
        chk(v == 32'd20, "R5 count write while busy", v, 32'd20);
        wr(A_CFG1, mkcfg(6, 3, 1'b1, 1'b1, 1'b1));
        rd(A_CFG1, v);
        chk(v == mkcfg(1, 8, 1'b1, 1'b0, 1'b0), "R5 config write while busy", v, mkcfg(1, 8, 1'b1, 1'b0, 1'b0));
        @(negedge clk);
        fifo_wr = 1'b1; fifo_wdata = 16'hBEEF;
        @(negedge clk);
        fifo_wr = 1'b0;
        rd(A_STAT, s);
        chk(s == 32'd20, "R8 push ignored in read mode", s, 32'd20);
        nand_rdy = 1'b1;
        repeat (3) @(negedge clk);
        nand_rdy = 1'b0;
        rd(A_STAT, s);
        chk(s == ((32'd3 << 24) | 32'd17), "R6 three bytes moved", s, (32'd3 << 24) | 32'd17);
        wr(A_CTRL, 32'd1);
        rd(A_STAT, s);
        chk(s == ((32'd3 << 24) | 32'd17), "R4 restart while busy ignored", s, (32'd3 << 24) | 32'd17);
        nand_rdy = 1'b1;
        wr(A_CTRL, 32'd0);
        rd(A_STAT, r0);
        repeat (5) begin
            @(negedge clk);
            #1;
            chk(nand_re == 1'b0, "R12 no strobe after stop", 32'(nand_re), 32'd0);
        end
        rd(A_STAT, s);
        chk(s == r0, "R12 remaining frozen after stop", s, r0);
        nand_rdy = 1'b0;
        wr(A_CFG2, 32'd7);
        rd(A_CFG2, v);
        chk(v == 32'd7, "R12 config writable after stop", v, 32'd7);
        wr(A_CFG1, 32'd0);

        // R7 / R11: short read, pop below four ignored, clear while set condition holds
        wr(A_CFG1, mkcfg(0, 1, 1'b1, 1'b1, 1'b0));
        wr(A_CFG2, 32'd3);
        wr(A_CTRL, 32'd1);
        nand_rdy = 1'b1;
        repeat (8) @(negedge clk);
        rd(A_STAT, s);
        chk(s == (32'd3 << 24), "R6 R9 three bytes held", s, 32'd3 << 24);
        fifo_rd = 1'b1;
        @(negedge clk);
        fifo_rd = 1'b0;
        rd(A_STAT, s);
        chk(s == (32'd3 << 24), "R7 pop below four ignored", s, 32'd3 << 24);
        wr(A_FLAG, 32'd1);
        rd(A_FLAG, v);
        chk(v == 32'd1, "R11 set wins over clear", v, 32'd1);
        nand_rdy = 1'b0;
        shut_down();

        // R8: push ignored when fewer than two bytes free
        wr(A_CFG1, mkcfg(3, 0, 1'b1, 1'b0, 1'b1));
        wr(A_CFG2, 32'd64);
        wr(A_CTRL, 32'd1);
        for (int k = 0; k < 33; k++) begin
            @(negedge clk);
            fifo_wr = 1'b1;
            fifo_wdata = {wpat(wpush + 1), wpat(wpush)};
            if (k < 32) wpush += 2;
        end
        @(negedge clk);
        fifo_wr = 1'b0;
        rd(A_STAT, s);
        chk(s == ((32'd64 << 24) | 32'd64), "R8 full FIFO refuses push", s, (32'd64 << 24) | 32'd64);
        nand_rdy = 1'b1;
        for (int g = 0; g < 200 && widx != wpush; g++) @(negedge clk);
        @(negedge clk);
        nand_rdy = 1'b0;
        rd(A_STAT, s);
        chk(s == 32'd0, "R8 full FIFO drained", s, 32'd0);
        shut_down();

        // Sweeps over lengths, ready patterns, thresholds and request modes
        for (int m = 0; m < 4; m++) begin
            for (int len = 4; len <= 64; len += 4)
                run_read(len, m, (len + m * 13) % 65, m[0]);
            for (int len = 2; len <= 64; len += 6)
                run_write(len, m, (len * 3 + m * 7) % 65, !m[0]);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule